// File: doc/BRIEF.md
# Memory-Card Slot Status Register Block

This block sits on a word-addressed register bus next to a memory-card slot. It watches two slot signals: a write-protect level and a card-present level. It gathers them into one status word and drives a single interrupt line. A card arrival is held in a sticky flag. The flag keeps the interrupt raised until software acknowledges it by writing a one to that flag's bit position. The write-protect state is reported live, inverted, next to the sticky flag.

Four word offsets are decoded:

| Offset | Contents |
|---|---|
| 0 | Fixed identification constant |
| 1 | Reserved word, reads zero, writes ignored |
| 2 | Slot status |
| 3 | Reserved word, reads zero, writes ignored |

Any access outside these four offsets raises an error strobe in the same cycle. Read data is combinational on the addressed word.

The interrupt output is a registered copy of the sticky flag, so it trails the flag by one clock.

Top module: `slot_status_regs`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the card flag (status bit 3) reads 0 and `irqOut` is 0.
- R2: A read at word offset 0 returns the parameter `ID_VALUE` (default 32'h0C5D_0001).
- R3: Reads at word offsets 1 and 3 return zero. Writes to offsets 1 and 3 change no readable state and leave `irqOut` unchanged.
- R4: Status word (offset 2) bit 0 equals the inverse of `wpIn` as sampled at the previous rising clock edge. Bits 1, 2 and 4 to 31 read as zero.
- R5: If `cardIn` is high at a rising edge, status bit 3 reads 1 after that edge. It stays 1 after `cardIn` falls, until an acknowledge clears it.
- R6: A write to offset 2 with data bit 3 set clears status bit 3 at that edge. A write to offset 2 with bit 3 clear leaves bit 3 unchanged. No other written bit has any effect.
- R7: If an acknowledge write and a high `cardIn` meet at the same edge, status bit 3 stays 1.
- R8: `irqOut` equals the value that status bit 3 held one clock earlier.
- R9: A read or write at any word offset of 4 or above asserts `busErr` in the same cycle. Such a read returns zero. Such a write changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wpIn | input | 1 | Write-protect level from the slot |
| cardIn | input | 1 | Card-present level from the slot |
| busAddr | input | ADDR_W | Word offset of the access |
| busRdEn | input | 1 | Read strobe |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data, zero when no valid read |
| busErr | output | 1 | Access to an undecoded offset |
| irqOut | output | 1 | Card-arrival interrupt |

## Verification
The assertions rely on three assumptions about the inputs:
- `busRdEn` and `busWrEn` are never high together.
- The bus inputs are stable from just after one rising edge to the next.
- Reset is held for at least one edge before any check, so the unreset write-protect flop has already loaded a value.

The stimulus changes every input a nanosecond after the edge. It issues at most one access per cycle and holds reset for several cycles. Card and write-protect levels are driven independently of the bus, including the acknowledge-during-insertion overlap and accesses past the last decoded word.

// File: rtl/slot_status_pkg.sv
package slot_status_pkg;

  // Bit positions inside the status word; software decodes these.
  localparam int WP_BIT   = 0;
  localparam int CARD_BIT = 3;

  // Word offsets decoded by the block.
  localparam int NUM_WORDS   = 4;
  localparam int OFF_ID      = 0;
  localparam int OFF_STATUS  = 2;

  // Strobes from the decoder to the datapath.
  typedef struct packed {
    logic rdId;
    logic rdStatus;
    logic wrStatus;
    logic badAccess;
  } strobe_t;

endpackage

// File: rtl/slot_status_ctrl.sv
module slot_status_ctrl
  import slot_status_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRdEn,
  input  logic              busWrEn,
  output strobe_t           strobes
);

  localparam logic [ADDR_W-1:0] ID_ADDR     = ADDR_W'(OFF_ID);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] LAST_ADDR   = ADDR_W'(NUM_WORDS - 1);

  logic inRange;

  always_comb begin
    inRange           = (busAddr <= LAST_ADDR);
    strobes           = '0;
    strobes.rdId      = busRdEn && (busAddr == ID_ADDR);
    strobes.rdStatus  = busRdEn && (busAddr == STATUS_ADDR);
    strobes.wrStatus  = busWrEn && (busAddr == STATUS_ADDR);
    // Offsets 1 and 3 are decoded but produce no strobe: zero reads, no-op writes.
    strobes.badAccess = (busRdEn || busWrEn) && !inRange;
  end

endmodule

// File: rtl/slot_status_dp.sv
module slot_status_dp
  import slot_status_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h0C5D_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wpIn,
  input  logic              cardIn,
  input  strobe_t           strobes,
  input  logic              ackBit,
  output logic [DATA_W-1:0] rdData,
  output logic              cardFlag,
  output logic              irqOut
);

  logic wpBit;
  logic [DATA_W-1:0] statusWord;

  // Live write-protect sample, inverted; not reset so it tracks from the first edge.
  always_ff @(posedge clk) begin
    wpBit <= ~wpIn;
  end

  // Sticky card flag: set beats acknowledge.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cardFlag <= 1'b0;
    end else if (cardIn) begin
      cardFlag <= 1'b1;
    end else if (strobes.wrStatus && ackBit) begin
      cardFlag <= 1'b0;
    end
  end

  // Interrupt is the flag delayed by one register.
  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= cardFlag;
  end

  always_comb begin
    statusWord           = '0;
    statusWord[WP_BIT]   = wpBit;
    statusWord[CARD_BIT] = cardFlag;
  end

  always_comb begin
    rdData = '0;
    if (strobes.rdId)     rdData = DATA_W'(ID_VALUE);
    if (strobes.rdStatus) rdData = statusWord;
  end

endmodule

// File: rtl/slot_status_regs.sv
module slot_status_regs
  import slot_status_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h0C5D_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wpIn,
  input  logic              cardIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRdEn,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              busErr,
  output logic              irqOut
);

  strobe_t strobes;
  logic    cardFlag;
  logic    unusedWrBits;

  // Only the acknowledge bit of the write data is consumed.
  assign unusedWrBits = ^busWrData;

  slot_status_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busRdEn (busRdEn),
    .busWrEn (busWrEn),
    .strobes (strobes)
  );

  slot_status_dp #(.DATA_W(DATA_W), .ID_VALUE(ID_VALUE)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wpIn     (wpIn),
    .cardIn   (cardIn),
    .strobes  (strobes),
    .ackBit   (busWrData[CARD_BIT]),
    .rdData   (busRdData),
    .cardFlag (cardFlag),
    .irqOut   (irqOut)
  );

  assign busErr = strobes.badAccess;

endmodule

// File: rtl/slot_status_chk.sv
module slot_status_chk #(
  parameter int          ADDR_W   = 4,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h0C5D_0001
) (
  input logic              clk,
  input logic              rstN,
  input logic              wpIn,
  input logic              cardIn,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRdEn,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic              busErr,
  input logic              irqOut,
  input logic              cardFlag
);

  logic ackWrite;
  assign ackWrite = busWrEn && (busAddr == ADDR_W'(2)) && busWrData[3];

  assert_id_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(0)) |-> (busRdData == DATA_W'(ID_VALUE)));

  assert_wp_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(2)) |-> (busRdData[0] == !$past(wpIn)));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cardFlag && !ackWrite) |=> cardFlag);

  assert_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ackWrite && !cardIn) |=> !cardFlag);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    cardIn |=> cardFlag);

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(cardFlag)));

  assert_bad_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr >= ADDR_W'(4)) |-> (busErr && busRdData == '0));

endmodule

bind slot_status_regs slot_status_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_VALUE(ID_VALUE)
) u_chk (
  .clk(clk), .rstN(rstN), .wpIn(wpIn), .cardIn(cardIn),
  .busAddr(busAddr), .busRdEn(busRdEn), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdData(busRdData), .busErr(busErr),
  .irqOut(irqOut), .cardFlag(cardFlag)
);

// File: tb/tb_slot_status_regs.sv
`timescale 1ns/1ps
module tb_slot_status_regs;

  localparam int          ADDR_W = 4;
  localparam int          DATA_W = 32;
  localparam logic [31:0] ID     = 32'h0C5D_0001;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wpIn = 1'b0;
  logic              cardIn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busRdEn = 1'b0;
  logic              busWrEn = 1'b0;
  logic [DATA_W-1:0] busWrData = '0;
  logic [DATA_W-1:0] busRdData;
  logic              busErr;
  logic              irqOut;

  int checks = 0;
  int fails  = 0;
  string curTag = "R1";

  // Reference state
  bit mFlag = 0;
  bit mIrq  = 0;
  bit mWp   = 1;

  always #2.5 clk = ~clk;

  slot_status_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_VALUE(ID)) dut (
    .clk(clk), .rstN(rstN), .wpIn(wpIn), .cardIn(cardIn),
    .busAddr(busAddr), .busRdEn(busRdEn), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .busErr(busErr),
    .irqOut(irqOut)
  );

  // Behavioural model, advanced at each edge from the inputs held across it.
  always @(posedge clk) begin
    mWp = !wpIn;
    if (!rstN) begin
      mFlag = 0;
      mIrq  = 0;
    end else begin
      mIrq = mFlag;
      if (cardIn) mFlag = 1;
      else if (busWrEn && busAddr == 4'd2 && busWrData[3]) mFlag = 0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!rstN) begin
      check("R1 irq in reset", {31'b0, irqOut}, 32'd0);
    end else begin
      logic [31:0] expRd;
      check("R8 irq", {31'b0, irqOut}, {31'b0, mIrq});
      if (busRdEn || busWrEn)
        check("R9 err", {31'b0, busErr}, {31'b0, (busAddr >= 4'd4)});
      if (busRdEn) begin
        case (busAddr)
          4'd0: begin expRd = ID; check("R2 id", busRdData, expRd); end
          4'd1, 4'd3: begin expRd = '0; check("R3 reserved", busRdData, expRd); end
          4'd2: begin
            expRd = '0; expRd[0] = mWp; expRd[3] = mFlag;
            check({curTag, " status"}, busRdData, expRd);
          end
          default: begin expRd = '0; check("R9 bad read", busRdData, expRd); end
        endcase
      end
    end
  end

  task automatic cyc(input bit wp, input bit card, input bit rd, input bit wr,
                     input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wpIn = wp; cardIn = card; busRdEn = rd; busWrEn = wr; busAddr = a; busWrData = d;
  endtask

  task automatic rdw(input bit wp, input bit card, input logic [3:0] a);
    cyc(wp, card, 1, 0, a, 32'h0);
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    curTag = "R1";
    rdw(0, 0, 2);                       // R1: flag clear after reset
    cyc(0, 0, 0, 0, 0, 0);
    curTag = "R2";
    rdw(0, 0, 0);
    curTag = "R3";
    cyc(0, 0, 0, 1, 1, 32'hFFFF_FFFF);
    cyc(0, 0, 0, 1, 3, 32'hFFFF_FFFF);
    rdw(0, 0, 1); rdw(0, 0, 3); rdw(0, 0, 2);
    curTag = "R4";
    cyc(1, 0, 0, 0, 0, 0);
    rdw(1, 0, 2); rdw(0, 0, 2); rdw(0, 0, 2);
    curTag = "R5";
    cyc(0, 1, 0, 0, 0, 0);
    rdw(0, 0, 2); rdw(0, 0, 2); rdw(1, 0, 2);
    curTag = "R6";
    cyc(0, 0, 0, 1, 2, 32'hFFFF_FFF7);  // bit 3 clear: no effect
    rdw(0, 0, 2);
    cyc(0, 0, 0, 1, 2, 32'h0000_0008);  // acknowledge
    rdw(0, 0, 2); rdw(0, 0, 2);
    curTag = "R7";
    cyc(0, 1, 0, 0, 0, 0);
    cyc(0, 1, 0, 1, 2, 32'h0000_0008);  // ack while card high
    rdw(0, 0, 2);
    curTag = "R9";
    cyc(0, 0, 0, 1, 5, 32'hFFFF_FFFF);
    rdw(0, 0, 9); rdw(0, 0, 15);
    curTag = "R5";
    rdw(0, 0, 2);
    // Mixed pattern, model checks every cycle
    curTag = "R6";
    for (int i = 0; i < 200; i++) begin
      logic [7:0] r;
      r = 8'(i * 37 + 11);
      cyc(r[0], (r[3:1] == 3'd5), r[4] & ~r[5], r[5], {1'b0, r[7:6] == 2'd3, r[6], r[4]},
          {28'h0, r[2], 3'b0});
    end
    cyc(0, 0, 0, 0, 0, 0);
    finishRun();
  end

endmodule